// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block turns the routing fields of one interrupt redirection entry into the set of processors that receive the interrupt. The inputs are a destination byte, an addressing mode, a delivery mode, the vector, the trigger mode and the number of the input pin that raised the request. Each processor slot reports three things as configuration: whether it is present, its physical ID and its logical ID. Each slot also reports a priority value, which is used for lowest-priority arbitration.

The block first works out the candidate set. Physical addressing either broadcasts to every present slot or picks a single slot by ID. Logical addressing picks every present slot whose logical ID shares a bit with the destination byte. The delivery mode then decides who actually receives the interrupt. Fixed delivery goes to the whole set. Lowest-priority delivery goes to the single slot with the smallest priority value.

Requests raised by pin 0 are always steered to slot 0. Delivery modes that are not supported deliver nothing. The result is registered: it appears one clock after the request, together with the vector, the trigger mode and an accepted flag.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical addressing (`addr_logical` = 0), destination 0xFF with a pin other than 0 and fixed delivery targets exactly the present slots.
- R2: In physical addressing with any destination other than 0xFF, only the lowest-indexed present slot whose physical ID equals the destination is targeted. No other slot is targeted, even when its ID also matches.
- R3: In logical addressing (`addr_logical` = 1), destination 0 targets no slot. A nonzero destination with fixed delivery targets every present slot whose logical ID ANDed with the destination is nonzero.
- R4: When the candidate set is empty, `res_targets` is all zero and `res_accepted` is 0.
- R5: Fixed delivery (`dlv_mode` = 3'd0), for any pin other than 0, targets every slot in the candidate set.
- R6: Lowest-priority delivery (`dlv_mode` = 3'd1), for any pin other than 0, targets exactly one slot. That slot is the candidate with the smallest `tgt_prio`; on a tie, the lowest index wins.
- R7: For pin 0, a non-empty candidate set under fixed or lowest-priority delivery targets slot 0 alone, provided slot 0 is present. If slot 0 is absent, nothing is targeted.
- R8: Any `dlv_mode` other than 3'd0 and 3'd1 targets nothing, and `res_accepted` is 0.
- R9: The result appears one cycle after `req_valid`. `res_valid` is high for exactly that cycle. `res_vector` and `res_trig_level` echo the request. `res_accepted` is 1 exactly when `res_targets` is nonzero. While `res_valid` is low, and after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_dest | input | 8 | Destination byte |
| addr_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| dlv_mode | input | 3 | 0 = fixed, 1 = lowest priority, others unsupported |
| req_vector | input | 8 | Interrupt vector |
| req_trig_level | input | 1 | Trigger mode, passed through |
| req_pin | input | PIN_W | Input pin number of the request |
| tgt_present | input | N_TGT | Per-slot presence flags |
| tgt_phys_id | input | N_TGT x 8 | Per-slot physical IDs |
| tgt_log_id | input | N_TGT x 8 | Per-slot logical IDs |
| tgt_prio | input | N_TGT x PRIO_W | Per-slot priority; smaller value wins |
| res_valid | output | 1 | Result is valid this cycle |
| res_targets | output | N_TGT | Delivery vector, one bit per slot |
| res_vector | output | 8 | Vector of the delivered request |
| res_trig_level | output | 1 | Trigger mode of the delivered request |
| res_accepted | output | 1 | At least one slot received the interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- every result is a subset of the slots that were present;
- physical unicast and lowest-priority results have at most one bit set;
- pin 0 results touch nothing but slot 0;
- unsupported modes deliver nothing;
- the accepted flag follows the delivery vector.

Which slot is correct, however, only the bench's sweeps can show. The bench compares every result against its own model over all destination bytes, both addressing modes, each delivery mode, with and without pin 0, and two presence and priority configurations. Those configurations include duplicate physical IDs, priority ties and an absent slot 0.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] DLV_FIXED  = 3'd0;
  localparam logic [MODE_W-1:0] DLV_LOWEST = 3'd1;
  localparam logic [DEST_W-1:0] DEST_ALL   = 8'hFF;
endpackage

// File: rtl/irq_dest_match.sv
// Builds the candidate set from the destination byte and addressing mode.
module irq_dest_match
  import irq_dest_pkg::*;
#(
  parameter int N_TGT = 8
) (
  input  logic [DEST_W-1:0]            dest,
  input  logic                         logical,
  input  logic [N_TGT-1:0]             present,
  input  logic [N_TGT-1:0][DEST_W-1:0] phys_id,
  input  logic [N_TGT-1:0][DEST_W-1:0] log_id,
  output logic [N_TGT-1:0]             cand
);
  logic [N_TGT-1:0] phys_hit;
  logic [N_TGT-1:0] log_hit;
  logic [N_TGT-1:0] phys_first;

  for (genvar g = 0; g < N_TGT; g++) begin : g_slot
    assign phys_hit[g] = present[g] && (phys_id[g] == dest);
    assign log_hit[g]  = present[g] && ((dest & log_id[g]) != '0);
  end

  // isolate the lowest set bit: only the first matching slot survives
  assign phys_first = phys_hit & (~phys_hit + {{(N_TGT-1){1'b0}}, 1'b1});

  always_comb begin
    if (logical) begin
      cand = (dest == '0) ? '0 : log_hit;
    end else if (dest == DEST_ALL) begin
      cand = present;
    end else begin
      cand = phys_first;
    end
  end
endmodule

// File: rtl/irq_lowest_pick.sv
// Picks one candidate with the smallest priority; ties go to the lower index.
module irq_lowest_pick #(
  parameter int N_TGT  = 8,
  parameter int PRIO_W = 4
) (
  input  logic [N_TGT-1:0]             cand,
  input  logic [N_TGT-1:0][PRIO_W-1:0] prio,
  output logic [N_TGT-1:0]             pick
);
  logic [PRIO_W-1:0] best;
  logic              found;

  always_comb begin
    pick  = '0;
    best  = '0;
    found = 1'b0;
    for (int i = 0; i < N_TGT; i++) begin
      if (cand[i] && (!found || (prio[i] < best))) begin
        pick    = '0;
        pick[i] = 1'b1;
        best    = prio[i];
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int N_TGT  = 8,
  parameter int PRIO_W = 4,
  parameter int PIN_W  = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [7:0]                   req_dest,
  input  logic                         addr_logical,
  input  logic [2:0]                   dlv_mode,
  input  logic [7:0]                   req_vector,
  input  logic                         req_trig_level,
  input  logic [PIN_W-1:0]             req_pin,
  input  logic [N_TGT-1:0]             tgt_present,
  input  logic [N_TGT-1:0][7:0]        tgt_phys_id,
  input  logic [N_TGT-1:0][7:0]        tgt_log_id,
  input  logic [N_TGT-1:0][PRIO_W-1:0] tgt_prio,
  output logic                         res_valid,
  output logic [N_TGT-1:0]             res_targets,
  output logic [7:0]                   res_vector,
  output logic                         res_trig_level,
  output logic                         res_accepted
);
  localparam logic [N_TGT-1:0] SLOT0 = {{(N_TGT-1){1'b0}}, 1'b1};

  logic [N_TGT-1:0] cand;
  logic [N_TGT-1:0] lowest;
  logic [N_TGT-1:0] deliver;

  irq_dest_match #(.N_TGT(N_TGT)) u_match (
    .dest    (req_dest),
    .logical (addr_logical),
    .present (tgt_present),
    .phys_id (tgt_phys_id),
    .log_id  (tgt_log_id),
    .cand    (cand)
  );

  irq_lowest_pick #(.N_TGT(N_TGT), .PRIO_W(PRIO_W)) u_pick (
    .cand (cand),
    .prio (tgt_prio),
    .pick (lowest)
  );

  always_comb begin
    deliver = '0;
    if ((cand != '0) && ((dlv_mode == DLV_FIXED) || (dlv_mode == DLV_LOWEST))) begin
      if (req_pin == '0) begin
        deliver = SLOT0 & tgt_present;
      end else if (dlv_mode == DLV_FIXED) begin
        deliver = cand;
      end else begin
        deliver = lowest;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_targets    <= '0;
      res_vector     <= '0;
      res_trig_level <= 1'b0;
      res_accepted   <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_targets    <= deliver;
        res_vector     <= req_vector;
        res_trig_level <= req_trig_level;
        res_accepted   <= (deliver != '0);
      end else begin
        res_targets    <= '0;
        res_vector     <= '0;
        res_trig_level <= 1'b0;
        res_accepted   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int N_TGT  = 8,
  parameter int PRIO_W = 4,
  parameter int PIN_W  = 5
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic [7:0]                   req_dest,
  input logic                         addr_logical,
  input logic [2:0]                   dlv_mode,
  input logic [PIN_W-1:0]             req_pin,
  input logic [N_TGT-1:0]             tgt_present,
  input logic                         res_valid,
  input logic [N_TGT-1:0]             res_targets,
  input logic                         res_accepted
);
  localparam logic [N_TGT-1:0] SLOT0 = {{(N_TGT-1){1'b0}}, 1'b1};

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid); // R9

  AST_ACCEPT_MATCHES_TARGETS: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_accepted == (res_targets != '0))); // R4

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ((res_targets == '0) && !res_accepted)); // R9

  AST_ONLY_PRESENT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ((res_targets & ~$past(tgt_present)) == '0)); // R1

  AST_PHYS_UNICAST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !addr_logical && (req_dest != 8'hFF)) |=> ($countones(res_targets) <= 1)); // R2

  AST_LOGICAL_ZERO_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && addr_logical && (req_dest == 8'h00)) |=> (res_targets == '0)); // R3

  AST_LOWEST_ONE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (dlv_mode == 3'd1)) |=> $onehot0(res_targets)); // R6

  AST_PIN0_SLOT0: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_pin == '0)) |=> ((res_targets & ~SLOT0) == '0)); // R7

  AST_UNSUPPORTED_DROP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (dlv_mode > 3'd1)) |=> ((res_targets == '0) && !res_accepted)); // R8
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(
  .N_TGT(N_TGT), .PRIO_W(PRIO_W), .PIN_W(PIN_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_dest     (req_dest),
  .addr_logical (addr_logical),
  .dlv_mode     (dlv_mode),
  .req_pin      (req_pin),
  .tgt_present  (tgt_present),
  .res_valid    (res_valid),
  .res_targets  (res_targets),
  .res_accepted (res_accepted)
);

// File: tb/tb_irq_dest_resolver.sv
`timescale 1ns/1ps
module tb_irq_dest_resolver;
  localparam int N = 8;
  localparam int PW = 4;
  localparam int PINW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [7:0] req_dest = '0;
  logic addr_logical = 1'b0;
  logic [2:0] dlv_mode = '0;
  logic [7:0] req_vector = '0;
  logic req_trig_level = 1'b0;
  logic [PINW-1:0] req_pin = '0;
  logic [N-1:0] tgt_present = '0;
  logic [N-1:0][7:0] tgt_phys_id = '0;
  logic [N-1:0][7:0] tgt_log_id = '0;
  logic [N-1:0][PW-1:0] tgt_prio = '0;
  logic res_valid;
  logic [N-1:0] res_targets;
  logic [7:0] res_vector;
  logic res_trig_level;
  logic res_accepted;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_dest_resolver #(.N_TGT(N), .PRIO_W(PW), .PIN_W(PINW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
    .addr_logical(addr_logical), .dlv_mode(dlv_mode), .req_vector(req_vector),
    .req_trig_level(req_trig_level), .req_pin(req_pin), .tgt_present(tgt_present),
    .tgt_phys_id(tgt_phys_id), .tgt_log_id(tgt_log_id), .tgt_prio(tgt_prio),
    .res_valid(res_valid), .res_targets(res_targets), .res_vector(res_vector),
    .res_trig_level(res_trig_level), .res_accepted(res_accepted)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent model of the candidate set
  function automatic logic [N-1:0] model_set(input logic [7:0] d, input logic lg);
    logic [N-1:0] s = '0;
    bit got = 1'b0;
    if (!lg) begin
      if (d == 8'hFF) s = tgt_present;
      else
        for (int i = 0; i < N; i++)
          if (!got && tgt_present[i] && tgt_phys_id[i] == d) begin
            s[i] = 1'b1;
            got = 1'b1;
          end
    end else if (d != 8'h00) begin
      for (int i = 0; i < N; i++)
        if (tgt_present[i] && ((d & tgt_log_id[i]) != 8'h00)) s[i] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [N-1:0] model_out(input logic [7:0] d, input logic lg,
                                             input logic [2:0] m, input logic [PINW-1:0] p);
    logic [N-1:0] s = model_set(d, lg);
    logic [N-1:0] r = '0;
    int best = 1 << PW;
    if (m > 3'd1 || s == '0) return '0;
    if (p == '0) begin
      r[0] = tgt_present[0];
      return r;
    end
    if (m == 3'd0) return s;
    for (int i = 0; i < N; i++)
      if (s[i] && int'(tgt_prio[i]) < best) begin
        best = int'(tgt_prio[i]);
        r = '0;
        r[i] = 1'b1;
      end
    return r;
  endfunction

  task automatic send(input logic [7:0] d, input logic lg, input logic [2:0] m,
                      input logic [PINW-1:0] p);
    logic [N-1:0] exp;
    string tag;
    @(negedge clk);
    req_valid = 1'b1; req_dest = d; addr_logical = lg; dlv_mode = m;
    req_pin = p; req_vector = d ^ 8'h5A; req_trig_level = d[0];
    exp = model_out(d, lg, m, p);
    if (m > 3'd1) tag = "R8 unsupported";
    else if (model_set(d, lg) == '0) tag = "R4 empty set";
    else if (p == '0) tag = "R7 pin0";
    else if (m == 3'd1) tag = "R6 lowest";
    else if (!lg && d == 8'hFF) tag = "R1 broadcast";
    else if (!lg) tag = "R2 physical";
    else tag = "R3 R5 logical fixed";
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, 32'(res_targets), 32'(exp));
    check("R9 accepted", 32'(res_accepted), 32'(exp != '0));
    check("R9 valid", 32'(res_valid), 32'd1);
    check("R9 vector", {23'd0, res_trig_level, res_vector}, {23'd0, d[0], d ^ 8'h5A});
  endtask

  task automatic sweep();
    for (int d = 0; d < 256; d++)
      for (int lg = 0; lg < 2; lg++)
        for (int m = 0; m < 2; m++) begin
          send(8'(d), lg[0], 3'(m), 5'd3);
          send(8'(d), lg[0], 3'(m), 5'd0);
        end
    for (int m = 2; m < 8; m++) begin
      send(8'hFF, 1'b0, 3'(m), 5'd4);
      send(8'h0F, 1'b1, 3'(m), 5'd4);
    end
  endtask

  initial begin
    #900000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      tgt_phys_id[i] = 8'(8'h10 + (i >> 1));
      tgt_log_id[i] = (i < 4) ? 8'(1 << i) : 8'(8'h11 << (i - 4));
      tgt_prio[i] = 4'((i * 5) % 4);
    end
    tgt_present = 8'b1011_1101;
    repeat (3) @(negedge clk);
    check("R9 reset valid", 32'(res_valid), 32'd0);
    check("R9 reset targets", 32'(res_targets), 32'd0);
    check("R9 reset accepted", 32'(res_accepted), 32'd0);
    rst = 1'b0;
    sweep();
    // second configuration: slot 0 absent, different priorities
    tgt_present = 8'b1111_1110;
    for (int i = 0; i < N; i++) tgt_prio[i] = 4'((7 * i + 3) % 8);
    sweep();
    // idle cycle after a request clears the outputs
    send(8'hFF, 1'b0, 3'd0, 5'd1);
    @(negedge clk);
    check("R9 idle valid", 32'(res_valid), 32'd0);
    check("R9 idle targets", 32'(res_targets), 32'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule